// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block models a small registered programmable logic array. There are eight dedicated inputs and eight macrocells. Each macrocell forms the OR of up to eight product terms, and each term is an AND over any chosen dedicated input, any macrocell feedback signal, or the complement of either. A per-macrocell polarity bit can invert the sum. A per-macrocell mode bit picks between two outputs: the sum itself, or a D flip-flop clocked by the single clock input that captures the sum. An enable bit on each pin decides whether the macrocell drives it. When a pin is not driven it serves as one more input to the array.

The configuration is a single bit vector. It is shifted in serially while a load enable is held high. The pins stay undriven from reset until the first load has finished. Finishing a load, or applying a synchronous reset, sets every flip-flop to its own configured start value. Sequence generators that must start from a known state, such as all ones, depend on this. The pins are modelled as separate value, enable and external-input ports rather than as electrical tristate pads.

Top module: `sop_array`

## Requirements
- R1: A product term is 1 exactly when every selected literal is true and at least one literal is selected. Array signal s is `dedicated_in[s]` for s = 0..7 and the feedback of macrocell s-8 for s = 8..15. In the 32-bit term field, bit 2s selects signal s true and bit 2s+1 selects it complemented.
- R2: A term that selects both polarities of one signal is 0. A term with no bit set contributes 0 to the sum.
- R3: A macrocell value is the OR of its 8 terms, XORed with its invert bit.
- R4: In registered mode the flip-flop captures the value at a rising `clk` edge and `pin_out[m]` shows the flip-flop. In combinational mode `pin_out[m]` follows the inputs with no clock delay.
- R5: The feedback of macrocell m into the array is its flip-flop when m is registered with its enable bit set. In every other case it is `pin_in[m]`.
- R6: While `cfg_load_en` is high, one bit of `cfg_sdi` is shifted in per clock. The bit shifted first ends up at configuration index 0 after 2080 shifts. Macrocell m occupies bits m*260 .. m*260+259. Term t of macrocell m is at offset t*32. Offset 256 is the mode bit (1 = registered), 257 the pin enable, 258 the invert bit and 259 the flip-flop start value.
- R7: `pin_oe` is all zero after reset and while loading. From the first clock edge that sees `cfg_load_en` low after a load, `pin_oe[m]` equals the enable bit of macrocell m.
- R8: A synchronous reset (`rst_n` low) and the completion of a load both set each flip-flop to its start value. While the configuration is not valid, the flip-flops hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | The only clock for the configuration chain and the macrocell flip-flops |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load_en | input | 1 | Shift enable for the serial configuration |
| cfg_sdi | input | 1 | Serial configuration data |
| dedicated_in | input | 8 | Dedicated array inputs |
| pin_in | input | 8 | External value on each pin, fed back when the pin is not driven by its flip-flop |
| pin_out | output | 8 | Value of each macrocell |
| pin_oe | output | 8 | Pin drive enable per macrocell |

## Verification
The main configuration is a 3-bit feedback shift register. Its XOR is built from product terms, and its all-ones start makes the first steps differ from a zeroed start. Combinational outputs gated by one input show whether feedback from a flip-flop reaches the array in the same cycle. A registered, inverted AND whose pin is not driven takes input pairs that separate the AND from the NAND and from a delay of one edge. An external value fed back on that undriven pin, set against the macrocell's own value, shows which source the array reads. A term holding both polarities of one signal, together with unused terms, must leave that output equal to the fed-back pin value alone. Resets in the middle of a run and reloads check start values, holding and the release of the pin enables.

// File: rtl/sop_array_pkg.sv
// Package: sizes and configuration layout shared by the array modules.
// Assumes the layout term fields, then mode, enable, invert, start value.
package sop_array_pkg;
    localparam int N_IN      = 8;
    localparam int N_MC      = 8;
    localparam int N_PT      = 8;
    localparam int N_SIG     = N_IN + N_MC;
    localparam int TERM_BITS = 2 * N_SIG;
    localparam int OFS_MODE  = N_PT * TERM_BITS;
    localparam int OFS_OE    = OFS_MODE + 1;
    localparam int OFS_INV   = OFS_MODE + 2;
    localparam int OFS_INIT  = OFS_MODE + 3;
    localparam int MC_BITS   = OFS_MODE + 4;
    localparam int CFG_BITS  = N_MC * MC_BITS;
endpackage

// File: rtl/sop_cfg_chain.sv
// Serial configuration store. Shifts cfg_sdi in toward index 0 while
// load_en is high, and flags when a load has completed.
// Assumes the stored bits need no reset, as they are rewritten by each load.
module sop_cfg_chain #(
    parameter int CFG_BITS = sop_array_pkg::CFG_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic                sdi,
    output logic [CFG_BITS-1:0] cfg,
    output logic                cfg_valid,
    output logic                cfg_done
);
    logic load_d;

    // Shift register holding the whole configuration vector.
    always_ff @(posedge clk) begin
        if (load_en)
            cfg <= {sdi, cfg[CFG_BITS-1:1]};
    end

    // Track the previous load enable so the end of a load can be seen.
    always_ff @(posedge clk) begin
        if (!rst_n) load_d <= 1'b0;
        else        load_d <= load_en;
    end

    assign cfg_done = load_d & ~load_en;

    // Configuration is valid from the end of a load until reset or a new load.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_valid <= 1'b0;
        else if (load_en)  cfg_valid <= 1'b0;
        else if (cfg_done) cfg_valid <= 1'b1;
    end

    // R7
    loading_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !cfg_valid);
    // R6
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(cfg));
endmodule

// File: rtl/sop_pterm.sv
// One product term. Two mask bits per signal: even bit selects it true,
// odd bit selects it complemented. An empty mask yields 0.
module sop_pterm #(
    parameter int N_SIG = sop_array_pkg::N_SIG
) (
    input  logic [N_SIG-1:0]   sig,
    input  logic [2*N_SIG-1:0] mask,
    output logic               hit
);
    logic [N_SIG-1:0] sel_t;
    logic [N_SIG-1:0] sel_c;

    for (genvar s = 0; s < N_SIG; s++) begin : g_split
        assign sel_t[s] = mask[2*s];
        assign sel_c[s] = mask[2*s+1];
    end

    // AND of all selected literals, gated by the term being used at all.
    always_comb begin
        hit = (|mask) & (&(sig | ~sel_t)) & (&(~sig | ~sel_c));
    end
endmodule

// File: rtl/sop_macrocell.sv
// One macrocell: OR of its product terms, polarity, optional flip-flop,
// and the choice of feedback source. Assumes cfg_done is only high while
// the configuration is not yet valid.
module sop_macrocell #(
    parameter int N_SIG   = sop_array_pkg::N_SIG,
    parameter int N_PT    = sop_array_pkg::N_PT,
    parameter int MC_BITS = sop_array_pkg::MC_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_valid,
    input  logic               cfg_done,
    input  logic [N_SIG-1:0]   sig,
    input  logic [MC_BITS-1:0] mc_cfg,
    input  logic               pin_ext,
    output logic               value,
    output logic               oe_bit,
    output logic               fb
);
    localparam int TB      = 2 * N_SIG;
    localparam int OFS_MOD = N_PT * TB;

    logic [N_PT-1:0] hits;
    logic            mode_reg;
    logic            inv;
    logic            init_v;
    logic            d;
    logic            q;

    assign mode_reg = mc_cfg[OFS_MOD];
    assign oe_bit   = mc_cfg[OFS_MOD+1];
    assign inv      = mc_cfg[OFS_MOD+2];
    assign init_v   = mc_cfg[OFS_MOD+3];

    for (genvar t = 0; t < N_PT; t++) begin : g_term
        sop_pterm #(.N_SIG(N_SIG)) u_term (
            .sig  (sig),
            .mask (mc_cfg[t*TB +: TB]),
            .hit  (hits[t])
        );
    end

    assign d = (|hits) ^ inv;

    // Macrocell flip-flop: start value on reset or load end, runs when valid.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_done)      q <= init_v;
        else if (cfg_valid && mode_reg) q <= d;
    end

    // Output value and feedback source selection.
    always_comb begin
        value = mode_reg ? q : d;
        fb    = (mode_reg && oe_bit) ? q : pin_ext;
    end

    // R4
    reg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && mode_reg && !cfg_done) |=> (q == $past(d)));
    // R8
    start_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> (q == $past(init_v)));
    // R8
    hold_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_valid && !cfg_done) |=> $stable(q));
endmodule

// File: rtl/sop_array.sv
// Top of the logic array: configuration chain plus macrocells. The array
// signal vector is the dedicated inputs followed by macrocell feedbacks.
// Assumes combinational feedback comes from the pin, so no loop forms inside.
module sop_array #(
    parameter int N_IN     = sop_array_pkg::N_IN,
    parameter int N_MC     = sop_array_pkg::N_MC,
    parameter int N_PT     = sop_array_pkg::N_PT,
    parameter int N_SIG    = N_IN + N_MC,
    parameter int MC_BITS  = N_PT * 2 * N_SIG + 4,
    parameter int CFG_BITS = N_MC * MC_BITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_load_en,
    input  logic            cfg_sdi,
    input  logic [N_IN-1:0] dedicated_in,
    input  logic [N_MC-1:0] pin_in,
    output logic [N_MC-1:0] pin_out,
    output logic [N_MC-1:0] pin_oe
);
    logic [CFG_BITS-1:0] cfg;
    logic                cfg_valid;
    logic                cfg_done;
    logic [N_MC-1:0]     fb;
    logic [N_MC-1:0]     oe_bits;
    logic [N_SIG-1:0]    sig;

    sop_cfg_chain #(.CFG_BITS(CFG_BITS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (cfg_load_en),
        .sdi       (cfg_sdi),
        .cfg       (cfg),
        .cfg_valid (cfg_valid),
        .cfg_done  (cfg_done)
    );

    assign sig = {fb, dedicated_in};

    for (genvar m = 0; m < N_MC; m++) begin : g_mc
        sop_macrocell #(.N_SIG(N_SIG), .N_PT(N_PT), .MC_BITS(MC_BITS)) u_mc (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_valid (cfg_valid),
            .cfg_done  (cfg_done),
            .sig       (sig),
            .mc_cfg    (cfg[m*MC_BITS +: MC_BITS]),
            .pin_ext   (pin_in[m]),
            .value     (pin_out[m]),
            .oe_bit    (oe_bits[m]),
            .fb        (fb[m])
        );
    end

    // Pins are driven only once a configuration is in place.
    always_comb begin
        pin_oe = cfg_valid ? oe_bits : '0;
    end

    // R7
    oe_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe != '0) |-> !$past(cfg_load_en));
endmodule

// File: tb/sop_array_test.sv
module sop_array_test;
    import sop_array_pkg::*;
    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_load_en = 1'b0;
    logic cfg_sdi = 1'b0;
    logic [7:0] dedicated_in = '0;
    logic [7:0] pin_in = '0;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int checks = 0;
    int fails = 0;
    logic [CFG_BITS-1:0] cfg = '0;
    logic [2:0] ref_q;

    // Vector: {show, a, b, c, p3, exp_mc4, exp_q3}
    localparam logic [6:0] VEC [12] = '{
        7'b1_00_0_0_0_1, 7'b1_11_0_1_1_0, 7'b1_10_1_0_0_1, 7'b1_01_1_1_1_1,
        7'b0_11_0_0_0_0, 7'b0_00_1_1_1_1, 7'b1_11_1_0_0_0, 7'b1_11_1_1_1_0,
        7'b1_10_0_1_1_1, 7'b0_01_0_0_0_1, 7'b1_11_0_1_1_0, 7'b1_00_1_0_0_1
    };

    sop_array uut (
        .clk(clk), .rst_n(rst_n), .cfg_load_en(cfg_load_en), .cfg_sdi(cfg_sdi),
        .dedicated_in(dedicated_in), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic lit(input int m, input int t, input int s, input int neg);
        cfg[m*MC_BITS + t*TERM_BITS + 2*s + neg] = 1'b1;
    endtask

    task automatic ctl(input int m, input logic reg_m, input logic oe,
                       input logic inv, input logic init);
        cfg[m*MC_BITS + OFS_MODE] = reg_m;
        cfg[m*MC_BITS + OFS_OE]   = oe;
        cfg[m*MC_BITS + OFS_INV]  = inv;
        cfg[m*MC_BITS + OFS_INIT] = init;
    endtask

    // R6: shift the vector in, index 0 first.
    task automatic load_cfg;
        @(negedge clk);
        cfg_load_en = 1'b1;
        for (int i = 0; i < CFG_BITS; i++) begin
            cfg_sdi = cfg[i];
            @(negedge clk);
            if (i == 5) check("R7 oe low while loading", pin_oe, 8'h00);
        end
        cfg_load_en = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [2:0] lfsr_next(input logic [2:0] q);
        lfsr_next = {(q[2] ^ q[0]) | ~(q[2] | q[1] | q[0]), q[2], q[1]};
    endfunction

    initial begin
        #(PERIOD*200000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // Sequence generator: q2=mc7, q1=mc6, q0=mc5 (signals 15, 14, 13).
        lit(7, 0, 15, 0); lit(7, 0, 13, 1);
        lit(7, 1, 15, 1); lit(7, 1, 13, 0);
        lit(7, 2, 15, 1); lit(7, 2, 14, 1); lit(7, 2, 13, 1);
        lit(6, 0, 15, 0); lit(5, 0, 14, 0);
        ctl(7, 1, 1, 0, 1); ctl(6, 1, 1, 0, 1); ctl(5, 1, 1, 0, 1);
        // Gated combinational copies, show = dedicated_in[7].
        lit(2, 0, 7, 0); lit(2, 0, 15, 0);
        lit(1, 0, 7, 0); lit(1, 0, 14, 0);
        lit(0, 0, 7, 0); lit(0, 0, 13, 0);
        ctl(2, 0, 1, 0, 0); ctl(1, 0, 1, 0, 0); ctl(0, 0, 1, 0, 0);
        // mc3: registered NAND of in0,in1, pin not driven, start 0.
        lit(3, 0, 0, 0); lit(3, 0, 1, 0);
        ctl(3, 1, 0, 1, 0);
        // mc4: contradictory term on in2 plus feedback of pin 3.
        lit(4, 0, 2, 0); lit(4, 0, 2, 1);
        lit(4, 1, 11, 0);
        ctl(4, 0, 1, 0, 0);

        repeat (3) @(negedge clk);
        check("R7 oe low after reset", pin_oe, 8'h00);
        rst_n = 1'b1;
        load_cfg();
        check("R7 oe after load", pin_oe, 8'b1111_0111);
        check("R8 start value after load", {5'b0, pin_out[7:5]}, 8'h07);
        check("R8 mc3 start value", {7'b0, pin_out[3]}, 8'h00);
        ref_q = 3'b111;

        for (int k = 0; k < 12; k++) begin
            logic [6:0] v;
            v = VEC[k];
            dedicated_in = {v[6], 4'b0, v[3], v[4], v[5]};
            pin_in = {4'b0, v[2], 3'b0};
            #1;
            // R1 R5: gated copies see flip-flop feedback at once
            check("R1 R5 gated outputs", {5'b0, pin_out[2:0]}, v[6] ? {5'b0, ref_q} : 8'h00);
            // R2 R5: contradictory and unused terms give 0, pin 3 read externally
            check("R2 R5 mc4 value", {7'b0, pin_out[4]}, {7'b0, v[1]});
            @(negedge clk);
            ref_q = lfsr_next(ref_q);
            check("R4 sequence step", {5'b0, pin_out[7:5]}, {5'b0, ref_q});
            check("R3 R4 registered NAND", {7'b0, pin_out[3]}, {7'b0, v[0]});
        end

        // Pin 3 external value against its own flip-flop value.
        dedicated_in = 8'h03;
        pin_in = 8'h08;
        @(negedge clk);
        check("R5 undriven pin source", {6'b0, pin_out[4], pin_out[3]}, 8'b10);

        // Reset in the middle of a run.
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 oe low on reset", pin_oe, 8'h00);
        check("R8 reset start values", {4'b0, pin_out[7:5], pin_out[3]}, 8'b1110);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 hold while not valid", {5'b0, pin_out[7:5]}, 8'h07);
        check("R7 oe stays low", pin_oe, 8'h00);
        load_cfg();
        check("R7 oe after reload", pin_oe, 8'b1111_0111);
        @(negedge clk);
        check("R4 first step after reload", {5'b0, pin_out[7:5]}, 8'b011);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule